// File: doc/BRIEF.md
# Destination Register Renamer with Commit-Time Mapping Check

This block renames the destination register of each instruction entering a small out-of-order core and checks its own rename state as instructions commit. It keeps a speculative map (logical to physical), a committed map, a FIFO of free physical registers and an in-order list of instructions in flight. On dispatch the free register at the head of the FIFO becomes the new mapping of the destination. The register it replaces is recorded alongside it in the in-flight list. On retirement the recorded replaced register must match the committed map's entry for the same logical register. These two copies should always agree, so any difference shows that rename state has been corrupted.

A health state machine holds two sticky conditions: a consistency fault and a retirement stall. It has four states. `HS_RUN` means no alarm. `HS_FAULT` means a mismatch was seen. `HS_HUNG` means the stall watchdog expired. `HS_BOTH` means both have happened. The transitions are as follows. A mismatch moves `HS_RUN` to `HS_FAULT` and `HS_HUNG` to `HS_BOTH`. Watchdog expiry moves `HS_RUN` to `HS_HUNG` and `HS_FAULT` to `HS_BOTH`. Both events in the same cycle move `HS_RUN` to `HS_BOTH`. No state is left except by reset.

A test port flips one chosen bit of one entry of either map, so that fault detection can be demonstrated.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i in both maps. The free FIFO holds physical registers NUM_LOG to NUM_PHYS-1 in ascending order, so the first allocation is NUM_LOG. `fault` and `wdog_alarm` are low.
- R2: While `disp_ready` is high, `disp_pdst` shows the head of the free FIFO and `disp_pold` shows the speculative mapping of `disp_ldst`. When `disp_valid` is also high, that register is allocated and becomes the new speculative mapping.
- R3: `disp_ready` is low when the free FIFO is empty or the in-flight list is full. While it is low, `disp_valid` changes no state.
- R4: When `ret_req` is high and the in-flight list is not empty, the oldest instruction retires in that cycle. `ret_done` is high, and `ret_ldst`/`ret_pdst`/`ret_pold` carry its logical destination, new register and replaced register. With an empty list, `ret_done` stays low.
- R5: If a retiring instruction's replaced register differs from the committed map entry of its logical destination, `fault` is high from the next cycle.
- R6: On retirement the committed map entry takes the new register, and the replaced register is appended to the tail of the free FIFO.
- R7: `fault` stays high until reset, through any later retirements.
- R8: A corrupted speculative map entry raises no fault on its own. The fault appears after the next instruction that overwrites that entry retires.
- R9: `wdog_alarm` rises after WDOG_LIMIT consecutive cycles in which the in-flight list is not empty and nothing retires. It stays high until reset. Idle cycles with an empty list do not count.
- R10: A cycle with `inj_en` high inverts bit `inj_bit` of entry `inj_idx` of the speculative map (`inj_arch`=0) or of the committed map (`inj_arch`=1).
- R11: A dispatch and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Instruction offered for renaming |
| disp_ldst | input | LW | Logical destination register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_pdst | output | PW | Physical register allocated |
| disp_pold | output | PW | Physical register being replaced |
| ret_req | input | 1 | Permission to retire the oldest instruction |
| ret_done | output | 1 | An instruction retires this cycle |
| ret_ldst | output | LW | Logical destination of the retiring instruction |
| ret_pdst | output | PW | New register of the retiring instruction |
| ret_pold | output | PW | Replaced register of the retiring instruction |
| fault | output | 1 | Sticky mapping-consistency fault |
| wdog_alarm | output | 1 | Sticky retirement-stall alarm |
| inj_en | input | 1 | Flip one map bit this cycle |
| inj_arch | input | 1 | 0 selects the speculative map, 1 the committed map |
| inj_idx | input | LW | Map entry to flip |
| inj_bit | input | BW | Bit within the entry to flip |

## Verification
Renaming is driven with several patterns. Distinct destinations check map indexing. Repeated renames of one register check that each replaced register is the previous allocation rather than the reset mapping. Filling the FIFO with retirement held off checks the stall and free-list ordering. Streaming dispatch and retirement in the same cycles checks concurrent table updates. Bit flips in each map separate a fault that is delayed until an overwriting instruction retires from a corruption in an entry that is never checked. A pending instruction with retirement withheld checks the watchdog count at its exact boundary against an empty list left idle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_FAULT = 2'd1,
        HS_HUNG  = 2'd2,
        HS_BOTH  = 2'd3
    } health_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ENTRIES = 8,
    parameter int PW      = 4,
    localparam int IW     = $clog2(ENTRIES),
    localparam int BW     = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [PW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_data,
    input  logic          flip_en,
    input  logic [IW-1:0] flip_idx,
    input  logic [BW-1:0] flip_bit
);
    logic [PW-1:0] ent_q [ENTRIES];
    logic [PW-1:0] ent_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && wr_idx == IW'(i))
                ent_d[i] = wr_data;
            if (flip_en && flip_idx == IW'(i))
                ent_d[i] = ent_d[i] ^ (PW'(1) << flip_bit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= PW'(i);
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_LOG  = 8,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int SLOTS   = NUM_PHYS - NUM_LOG,
    localparam int PTRW    = $clog2(SLOTS),
    localparam int CW      = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_id,
    output logic [PW-1:0] head_id,
    output logic [CW-1:0] count
);
    logic [PW-1:0]   slot_q [SLOTS];
    logic [PTRW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (p == PTRW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOTS; k++) slot_q[k] <= PW'(NUM_LOG + k);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(SLOTS);
        end else begin
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push) begin
                slot_q[wr_ptr] <= push_id;
                wr_ptr         <= bump(wr_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_id = slot_q[rd_ptr];
endmodule

// File: rtl/rn_active_list.sv
module rn_active_list #(
    parameter int DEPTH  = 16,
    parameter int EW     = 11,
    localparam int PTRW  = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_ent,
    input  logic          pop,
    output logic [EW-1:0] head_ent,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [EW-1:0]   ent_q [DEPTH];
    logic [PTRW-1:0] hd_ptr, tl_ptr;

    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
            hd_ptr <= '0;
            tl_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                ent_q[tl_ptr] <= push_ent;
                tl_ptr        <= bump(tl_ptr);
            end
            if (pop) hd_ptr <= bump(hd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_ent = ent_q[hd_ptr];
    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
endmodule

// File: rtl/rn_health_fsm.sv
module rn_health_fsm
    import rn_pkg::*;
#(
    parameter int WDOG_LIMIT = 32,
    localparam int WCW       = $clog2(WDOG_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_fire,
    input  logic pending,
    input  logic check_fail,
    output logic fault_flag,
    output logic hang_flag
);
    health_e        st_q, st_d;
    logic [WCW-1:0] idle_cnt;
    logic           expire;

    // A stall cycle is one with work pending and no retirement.
    assign expire = pending && !retire_fire && (idle_cnt == WCW'(WDOG_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       idle_cnt <= '0;
        else if (!pending || retire_fire) idle_cnt <= '0;
        else if (idle_cnt != WCW'(WDOG_LIMIT)) idle_cnt <= idle_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN: begin
                if (check_fail && expire) st_d = HS_BOTH;
                else if (check_fail)      st_d = HS_FAULT;
                else if (expire)          st_d = HS_HUNG;
            end
            HS_FAULT: if (expire)     st_d = HS_BOTH;
            HS_HUNG:  if (check_fail) st_d = HS_BOTH;
            HS_BOTH:  st_d = HS_BOTH;
            default:  st_d = HS_RUN;
        endcase
    end

    always_comb begin
        fault_flag = 1'b0;
        hang_flag  = 1'b0;
        unique case (st_q)
            HS_RUN:   ;
            HS_FAULT: fault_flag = 1'b1;
            HS_HUNG:  hang_flag  = 1'b1;
            HS_BOTH: begin
                fault_flag = 1'b1;
                hang_flag  = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int NUM_LOG    = 8,
    parameter int NUM_PHYS   = 16,
    parameter int AL_DEPTH   = 16,
    parameter int WDOG_LIMIT = 32,
    localparam int LW        = $clog2(NUM_LOG),
    localparam int PW        = $clog2(NUM_PHYS),
    localparam int BW        = $clog2(PW),
    localparam int SLOTS     = NUM_PHYS - NUM_LOG,
    localparam int FCW       = $clog2(SLOTS + 1),
    localparam int ACW       = $clog2(AL_DEPTH + 1),
    localparam int EW        = LW + 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic [LW-1:0] disp_ldst,
    output logic          disp_ready,
    output logic [PW-1:0] disp_pdst,
    output logic [PW-1:0] disp_pold,
    input  logic          ret_req,
    output logic          ret_done,
    output logic [LW-1:0] ret_ldst,
    output logic [PW-1:0] ret_pdst,
    output logic [PW-1:0] ret_pold,
    output logic          fault,
    output logic          wdog_alarm,
    input  logic          inj_en,
    input  logic          inj_arch,
    input  logic [LW-1:0] inj_idx,
    input  logic [BW-1:0] inj_bit
);
    logic [FCW-1:0] fl_count;
    logic [ACW-1:0] al_count;
    logic           al_empty, al_full;
    logic [EW-1:0]  al_head;
    logic [PW-1:0]  arch_rd;
    logic           disp_fire, ret_fire, check_fail;

    assign disp_ready = (fl_count != '0) && !al_full;
    assign disp_fire  = disp_valid && disp_ready;
    assign ret_fire   = ret_req && !al_empty;
    assign ret_done   = ret_fire;
    assign {ret_ldst, ret_pdst, ret_pold} = al_head;
    assign check_fail = ret_fire && (ret_pold != arch_rd);

    rn_map_table #(.ENTRIES(NUM_LOG), .PW(PW)) u_spec_map (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(disp_ldst), .rd_data(disp_pold),
        .wr_en(disp_fire), .wr_idx(disp_ldst), .wr_data(disp_pdst),
        .flip_en(inj_en && !inj_arch), .flip_idx(inj_idx), .flip_bit(inj_bit)
    );

    rn_map_table #(.ENTRIES(NUM_LOG), .PW(PW)) u_arch_map (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ret_ldst), .rd_data(arch_rd),
        .wr_en(ret_fire), .wr_idx(ret_ldst), .wr_data(ret_pdst),
        .flip_en(inj_en && inj_arch), .flip_idx(inj_idx), .flip_bit(inj_bit)
    );

    rn_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop(disp_fire), .push(ret_fire), .push_id(ret_pold),
        .head_id(disp_pdst), .count(fl_count)
    );

    rn_active_list #(.DEPTH(AL_DEPTH), .EW(EW)) u_inflight (
        .clk(clk), .rst_n(rst_n),
        .push(disp_fire), .push_ent({disp_ldst, disp_pdst, disp_pold}),
        .pop(ret_fire), .head_ent(al_head),
        .count(al_count), .empty(al_empty), .full(al_full)
    );

    rn_health_fsm #(.WDOG_LIMIT(WDOG_LIMIT)) u_health (
        .clk(clk), .rst_n(rst_n),
        .retire_fire(ret_fire), .pending(!al_empty), .check_fail(check_fail),
        .fault_flag(fault), .hang_flag(wdog_alarm)
    );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int AL_DEPTH = 16,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int SLOTS   = NUM_PHYS - NUM_LOG,
    localparam int FCW     = $clog2(SLOTS + 1),
    localparam int ACW     = $clog2(AL_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           disp_ready,
    input logic           ret_done,
    input logic [PW-1:0]  ret_pold,
    input logic [PW-1:0]  arch_at_ret,
    input logic           fault,
    input logic           wdog_alarm,
    input logic [FCW-1:0] fl_count,
    input logic [ACW-1:0] al_count
);
    a_r5_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && ret_pold != arch_at_ret) |=> fault);

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_alarm |=> wdog_alarm);

    a_r9_alarm_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_alarm) |-> $past(al_count != '0 && !ret_done));

    a_r3_stall_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0 || al_count == ACW'(AL_DEPTH)) |-> !disp_ready);

    a_r4_no_retire_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (al_count == '0) |-> !ret_done);

    a_r6_registers_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fl_count) + int'(al_count)) == SLOTS);
endmodule

bind rename_unit rename_unit_chk #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .AL_DEPTH(AL_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_ready(disp_ready), .ret_done(ret_done),
    .ret_pold(ret_pold), .arch_at_ret(arch_rd), .fault(fault),
    .wdog_alarm(wdog_alarm), .fl_count(fl_count), .al_count(al_count)
);

// File: tb/rename_unit_test.sv
module rename_unit_test;
    localparam int NL = 8;
    localparam int NP = 16;
    localparam int AD = 16;
    localparam int WD = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid, disp_ready, ret_req, ret_done, fault, wdog_alarm;
    logic       inj_en, inj_arch;
    logic [2:0] disp_ldst, ret_ldst, inj_idx;
    logic [3:0] disp_pdst, disp_pold, ret_pdst, ret_pold;
    logic [1:0] inj_bit;

    always #5 clk = ~clk;

    rename_unit #(.NUM_LOG(NL), .NUM_PHYS(NP), .AL_DEPTH(AD), .WDOG_LIMIT(WD)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ldst(disp_ldst),
        .disp_ready(disp_ready), .disp_pdst(disp_pdst), .disp_pold(disp_pold),
        .ret_req(ret_req), .ret_done(ret_done), .ret_ldst(ret_ldst),
        .ret_pdst(ret_pdst), .ret_pold(ret_pold), .fault(fault),
        .wdog_alarm(wdog_alarm), .inj_en(inj_en), .inj_arch(inj_arch),
        .inj_idx(inj_idx), .inj_bit(inj_bit)
    );

    int checks = 0;
    int failures = 0;
    int fl_q[$];
    int spec_m[NL];
    int arch_m[NL];
    int e_ld[$];
    int e_pd[$];
    int e_po[$];
    bit exp_fault;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_init();
        fl_q.delete();
        for (int i = NL; i < NP; i++) fl_q.push_back(i);
        for (int i = 0; i < NL; i++) begin
            spec_m[i] = i;
            arch_m[i] = i;
        end
        e_ld.delete(); e_pd.delete(); e_po.delete();
        exp_fault = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; disp_valid = 1'b0; ret_req = 1'b0; inj_en = 1'b0;
        model_init();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: offers one dispatch and pushes the expected retirement.
    task automatic do_disp(input int ld);
        int pd;
        disp_ldst  = 3'(ld);
        disp_valid = 1'b1;
        while (!disp_ready) @(negedge clk);
        pd = fl_q[0];
        chk(disp_pdst == 4'(pd), "R2/R6 allocated register", disp_pdst, pd);
        chk(disp_pold == 4'(spec_m[ld]), "R2 replaced register", disp_pold, spec_m[ld]);
        e_ld.push_back(ld); e_pd.push_back(pd); e_po.push_back(spec_m[ld]);
        spec_m[ld] = pd;
        void'(fl_q.pop_front());
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic inject(input bit sel, input int idx, input int b);
        inj_arch = sel; inj_idx = 3'(idx); inj_bit = 2'(b); inj_en = 1'b1;
        if (sel) arch_m[idx] = arch_m[idx] ^ (1 << b);
        else     spec_m[idx] = spec_m[idx] ^ (1 << b);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic drain();
        ret_req = 1'b1;
        while (e_ld.size() != 0) @(negedge clk);
        @(negedge clk);
        ret_req = 1'b0;
    endtask

    // Monitor: compares every retirement and the fault flag.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(fault == exp_fault, "R5/R7 fault flag", fault, exp_fault);
            if (ret_done) begin
                if (e_ld.size() == 0) begin
                    chk(1'b0, "R4 unexpected retirement", 1, 0);
                end else begin
                    int el, ep, eo;
                    el = e_ld.pop_front(); ep = e_pd.pop_front(); eo = e_po.pop_front();
                    chk(ret_ldst == 3'(el), "R4 retire ldst", ret_ldst, el);
                    chk(ret_pdst == 4'(ep), "R4 retire pdst", ret_pdst, ep);
                    chk(ret_pold == 4'(eo), "R4 retire pold", ret_pold, eo);
                    if (eo != arch_m[el]) exp_fault = 1'b1;
                    arch_m[el] = ep;
                    fl_q.push_back(eo);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL timeout watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; disp_valid = 1'b0; disp_ldst = '0; ret_req = 1'b0;
        inj_en = 1'b0; inj_arch = 1'b0; inj_idx = '0; inj_bit = '0;
        do_reset();

        // R1 reset contents
        disp_ldst = 3'd3; ret_req = 1'b1;
        #1;
        chk(disp_ready == 1'b1, "R1 ready after reset", disp_ready, 1);
        chk(disp_pdst == 4'd8, "R1 first free register", disp_pdst, 8);
        chk(disp_pold == 4'd3, "R1 identity mapping", disp_pold, 3);
        chk(fault == 1'b0, "R1 fault low", fault, 0);
        chk(wdog_alarm == 1'b0, "R1 alarm low", wdog_alarm, 0);
        chk(ret_done == 1'b0, "R4 no retirement when empty", ret_done, 0);
        @(negedge clk);
        ret_req = 1'b0;

        // Distinct destinations, then retire
        for (int k = 0; k < 4; k++) do_disp(k);
        drain();
        // Same destination repeatedly
        for (int k = 0; k < 4; k++) do_disp(1);
        drain();

        // R3 free FIFO exhausted
        for (int k = 0; k < NP - NL; k++) do_disp(k);
        chk(disp_ready == 1'b0, "R3 stall on empty free FIFO", disp_ready, 0);
        disp_ldst = 3'd5; disp_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(disp_ready == 1'b0, "R3 still stalled", disp_ready, 0);
        chk(disp_pold == 4'(spec_m[5]), "R3 stalled dispatch changes nothing", disp_pold, spec_m[5]);
        disp_valid = 1'b0;
        drain();

        // R11 concurrent dispatch and retirement
        ret_req = 1'b1;
        for (int k = 0; k < 12; k++) do_disp(k % NL);
        drain();
        chk(e_ld.size() == 0, "R11 all streamed instructions retired", e_ld.size(), 0);

        // R8/R10 speculative map corruption
        do_reset();
        inject(1'b0, 2, 0);
        repeat (5) @(negedge clk);
        chk(fault == 1'b0, "R8 no fault at corruption", fault, 0);
        do_disp(2);
        chk(fault == 1'b0, "R8 no fault before retirement", fault, 0);
        drain();
        chk(fault == 1'b1, "R8 fault after overwriting retirement", fault, 1);
        do_disp(4);
        drain();
        chk(fault == 1'b1, "R7 fault sticky", fault, 1);

        // R10 committed map corruption
        do_reset();
        inject(1'b1, 5, 1);
        do_disp(6);
        drain();
        chk(fault == 1'b0, "R10 unrelated entry clean", fault, 0);
        do_disp(5);
        drain();
        chk(fault == 1'b1, "R10 committed map flip detected", fault, 1);

        // R9 watchdog
        do_reset();
        repeat (WD + 5) @(negedge clk);
        chk(wdog_alarm == 1'b0, "R9 idle with empty list", wdog_alarm, 0);
        do_disp(0);
        repeat (WD - 1) @(negedge clk);
        chk(wdog_alarm == 1'b0, "R9 alarm low one cycle early", wdog_alarm, 0);
        @(negedge clk);
        chk(wdog_alarm == 1'b1, "R9 alarm at limit", wdog_alarm, 1);
        drain();
        chk(wdog_alarm == 1'b1, "R9 alarm sticky", wdog_alarm, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule